// File: doc/BRIEF.md
# TLB management register interface

This block gives a processor register-level control over a software-managed translation buffer. It owns the buffer's storage: a tag word, a 64-bit data word and an 8-bit translation ID for every entry. It also holds three control registers: an index register, a process-ID register and a zone-protection register. A write-only search register completes the set.

Every access is a single-cycle operation on one register number. Write data is committed on the rising clock edge. Read data follows the register number combinationally.

Several accesses act on registers other than the one addressed:
- Writing the entry tag records the current process ID in that entry.
- Reading the entry tag copies the entry's ID back into the process-ID register.
- Writing the search register runs a one-cycle associative lookup, and the result lands in the index register.

Two configuration inputs choose how much of the interface is reachable. One gives the translation-unit level and the other gives the buffer-access level.

Top module: `tlbreg_ctrl`

## Requirements
- R1: Register numbers are 0 entry-data, 1 entry-tag, 2 index, 3 search, 4 process ID and 5 zone protection; 6 and 7 are undefined. After reset, every register and every stored entry word and ID is zero.
- R2: When `mmu_level` is below 2 or `tlb_access` is 0, every read returns 0 and every write leaves all state unchanged.
- R3: An extended access (`acc_ext`=1) reaches the upper 32 bits of the entry's 64-bit data word, and only through register 0. Extended accesses to any other register read 0 and change nothing.
- R4: Reads of registers 0, 1, 4 and 5 return 0 unless `tlb_access` bit 0 is set. The index register is readable at any enabled access level.
- R5: Writes to registers 4, 5 and 3 take effect only when `tlb_access` is 2 or 3. Writes to registers 0, 1 and 2 need only the enabled condition of R2.
- R6: Registers 0 and 1 act on the entry chosen by the low log2(ENTRIES) bits of the index register. Register 0 holds data bits [31:0]; register 1 holds the tag word.
- R7: A write to register 1 stores process-ID bits [7:0] as that entry's translation ID.
- R8: A permitted non-extended read of register 1 loads the process-ID register with the entry's translation ID, zero-extended.
- R9: Index bit 31 is a read-only miss flag. A write to register 2 updates only bits [30:0].
- R10: A search runs on write-data bits [31:10]. An entry matches when all of the following hold:
  - tag bit 6 (valid) is set;
  - the addresses agree above the page size 1 KiB×4^s, where s is tag bits [9:7];
  - its ID is 0 or equals process-ID bits [7:0].
  The lowest matching index wins.
- R11: An entry's zone is data bits [7:4]. Its 2-bit protection code is zone-register bits [31-2z:30-2z]. When `user_mode` is 1, an entry whose code is 0 does not match. A zone number above ZONE_MAX imposes no restriction.
- R12: On a search hit, the whole index register becomes the hit index, which clears bit 31. On a miss, bit 31 is set and bits [30:0] keep their value.
- R13: Reads of the search register and of undefined registers return 0. Writes to undefined registers change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| mmu_level | input | 2 | Translation-unit presence level |
| tlb_access | input | 2 | Buffer-access level |
| user_mode | input | 1 | Current privilege for searches (1 = user) |
| acc_en | input | 1 | Access valid this cycle |
| acc_wr | input | 1 | 1 = write, 0 = read |
| acc_ext | input | 1 | Extended (upper-word) access |
| acc_reg | input | 3 | Register number |
| acc_wdata | input | 32 | Write data |
| acc_rdata | output | 32 | Read data, combinational |

## Verification
The bench builds the block with 8 entries and ZONE_MAX of 3. With that configuration:
- the 3-bit entry select wraps on wide index values;
- zone numbers 4 to 15 reach the out-of-range case of R11;
- a complete readback of all storage stays short.

Every combination of the 16 configuration levels, 8 register numbers and both extended settings is swept for reads and then for writes. A bench-side model predicts each result. Searches cover page sizes from 1 KiB to 16 MiB, overlapping entries, ID filtering and both privilege modes under three zone settings.

// File: rtl/tlbreg_pkg.sv
package tlbreg_pkg;

  // Register numbers
  localparam logic [2:0] RN_DATA   = 3'd0;
  localparam logic [2:0] RN_TAG    = 3'd1;
  localparam logic [2:0] RN_INDEX  = 3'd2;
  localparam logic [2:0] RN_SEARCH = 3'd3;
  localparam logic [2:0] RN_PID    = 3'd4;
  localparam logic [2:0] RN_ZONE   = 3'd5;

  // Field positions decoded by the lookup
  localparam int VALID_BIT = 6;
  localparam int SIZE_LSB  = 7;
  localparam int PAGE_LSB  = 10;
  localparam int ZSEL_LSB  = 4;

  typedef struct packed {
    logic wr_dlo;
    logic wr_dhi;
    logic wr_tag;
    logic rd_tag;
    logic wr_index;
    logic wr_search;
    logic wr_pid;
    logic wr_zone;
  } tlb_strobe_t;

  // Mask of address bits that select a page of size 1 KiB * 4^code
  function automatic logic [31:0] page_mask(input logic [2:0] code);
    logic [31:0] span;
    span = 32'd1024 << {code, 1'b0};
    return ~(span - 32'd1);
  endfunction

  function automatic logic [31:0] page_bits(input logic [31:0] v);
    return v & ~((32'd1 << PAGE_LSB) - 32'd1);
  endfunction

endpackage

// File: rtl/tlbreg_access.sv
module tlbreg_access
  import tlbreg_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        acc_en,
  input  logic        acc_wr,
  input  logic        acc_ext,
  input  logic [2:0]  acc_reg,
  input  logic [1:0]  mmu_level,
  input  logic [1:0]  tlb_access,
  output tlb_strobe_t strobe,
  output logic        rd_ok
);

  logic present, ext_ok, rd_priv, wr_priv, do_wr, do_rd;

  always_comb begin
    present = (mmu_level >= 2'd2) && (tlb_access != 2'd0);
    ext_ok  = !acc_ext || (acc_reg == RN_DATA);
    rd_priv = tlb_access[0];
    wr_priv = tlb_access[1];
    do_wr   = acc_en && acc_wr && present && ext_ok;
    do_rd   = acc_en && !acc_wr && present && ext_ok;

    strobe = '0;
    if (do_wr) begin
      case (acc_reg)
        RN_DATA: begin
          strobe.wr_dlo = !acc_ext;
          strobe.wr_dhi = acc_ext;
        end
        RN_TAG:    strobe.wr_tag    = 1'b1;
        RN_INDEX:  strobe.wr_index  = 1'b1;
        RN_SEARCH: strobe.wr_search = wr_priv;
        RN_PID:    strobe.wr_pid    = wr_priv;
        RN_ZONE:   strobe.wr_zone   = wr_priv;
        default:   strobe = '0;
      endcase
    end
    strobe.rd_tag = do_rd && (acc_reg == RN_TAG) && rd_priv;

    rd_ok = 1'b0;
    if (present && ext_ok) begin
      case (acc_reg)
        RN_DATA, RN_TAG, RN_PID, RN_ZONE: rd_ok = rd_priv;
        RN_INDEX: rd_ok = 1'b1;
        default:  rd_ok = 1'b0;
      endcase
    end
  end

  // R5: a single access never fires more than one action
  p_one_action_r5: assert property (@(posedge clk) disable iff (rst)
    $onehot0(strobe));

endmodule

// File: rtl/tlbreg_store.sv
module tlbreg_store #(
  parameter int ENTRIES = 64,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [IDX_W-1:0]           sel,
  input  logic                       wr_dlo,
  input  logic                       wr_dhi,
  input  logic                       wr_tag,
  input  logic [31:0]                wdata,
  input  logic [7:0]                 pid8,
  output logic [31:0]                rd_dlo,
  output logic [31:0]                rd_dhi,
  output logic [31:0]                rd_tag,
  output logic [7:0]                 rd_tid,
  output logic [ENTRIES-1:0][31:0]   tag_all,
  output logic [ENTRIES-1:0][3:0]    zone_all,
  output logic [ENTRIES-1:0][7:0]    tid_all
);
  import tlbreg_pkg::*;

  logic [ENTRIES-1:0][31:0] tag_q, dlo_q, dhi_q;
  logic [ENTRIES-1:0][7:0]  tid_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      tag_q <= '0;
      dlo_q <= '0;
      dhi_q <= '0;
      tid_q <= '0;
    end else begin
      for (int i = 0; i < ENTRIES; i++) begin
        if (sel == IDX_W'(i)) begin
          if (wr_tag) begin
            tag_q[i] <= wdata;
            tid_q[i] <= pid8;
          end
          if (wr_dlo) dlo_q[i] <= wdata;
          if (wr_dhi) dhi_q[i] <= wdata;
        end
      end
    end
  end

  assign rd_dlo  = dlo_q[sel];
  assign rd_dhi  = dhi_q[sel];
  assign rd_tag  = tag_q[sel];
  assign rd_tid  = tid_q[sel];
  assign tag_all = tag_q;
  assign tid_all = tid_q;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_zone
    assign zone_all[g] = dlo_q[g][ZSEL_LSB +: 4];
  end

  // R3: an upper-word write lands in the upper word and leaves the lower one
  p_upper_word_r3: assert property (@(posedge clk) disable iff (rst)
    wr_dhi |=> (rd_dhi == $past(wdata)) && (rd_dlo == $past(rd_dlo)));

  // R6: a lower-word write lands in the lower word and leaves the upper one
  p_lower_word_r6: assert property (@(posedge clk) disable iff (rst)
    wr_dlo |=> (rd_dlo == $past(wdata)) && (rd_dhi == $past(rd_dhi)));

endmodule

// File: rtl/tlbreg_search.sv
module tlbreg_search #(
  parameter int ENTRIES  = 64,
  parameter int ZONE_MAX = 15,
  localparam int IDX_W   = $clog2(ENTRIES)
) (
  input  logic [ENTRIES-1:0][31:0] tag_all,
  input  logic [ENTRIES-1:0][3:0]  zone_all,
  input  logic [ENTRIES-1:0][7:0]  tid_all,
  input  logic [31:0]              vaddr,
  input  logic [7:0]               pid8,
  input  logic [31:0]              zpr,
  input  logic                     user,
  output logic                     hit,
  output logic [IDX_W-1:0]         hit_idx
);
  import tlbreg_pkg::*;

  logic [ENTRIES-1:0] match;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    logic [1:0]  zfld;
    logic [31:0] mask;
    logic        addr_eq, id_ok;

    assign mask    = page_mask(tag_all[g][SIZE_LSB +: 3]);
    assign addr_eq = ((vaddr ^ tag_all[g]) & mask) == 32'd0;
    assign id_ok   = (tid_all[g] == 8'd0) || (tid_all[g] == pid8);
    assign zfld    = (int'(zone_all[g]) > ZONE_MAX) ? 2'b01
                   : 2'(zpr >> (5'd30 - {zone_all[g], 1'b0}));
    assign match[g] = tag_all[g][VALID_BIT] && addr_eq && id_ok
                    && !(user && (zfld == 2'b00));
  end

  // lowest matching index wins
  always_comb begin
    hit     = |match;
    hit_idx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (match[i]) hit_idx = IDX_W'(i);
    end
  end

endmodule

// File: rtl/tlbreg_ctrl.sv
module tlbreg_ctrl
  import tlbreg_pkg::*;
#(
  parameter int ENTRIES  = 64,
  parameter int ZONE_MAX = 15
) (
  input  logic        clk,
  input  logic        rst,
  input  logic [1:0]  mmu_level,
  input  logic [1:0]  tlb_access,
  input  logic        user_mode,
  input  logic        acc_en,
  input  logic        acc_wr,
  input  logic        acc_ext,
  input  logic [2:0]  acc_reg,
  input  logic [31:0] acc_wdata,
  output logic [31:0] acc_rdata
);

  localparam int IDX_W = $clog2(ENTRIES);

  tlb_strobe_t st;
  logic        rd_ok;
  logic [31:0] index_q, pid_q, zpr_q;
  logic [31:0] rd_dlo, rd_dhi, rd_tag;
  logic [7:0]  rd_tid;
  logic [ENTRIES-1:0][31:0] tag_all;
  logic [ENTRIES-1:0][3:0]  zone_all;
  logic [ENTRIES-1:0][7:0]  tid_all;
  logic                     hit;
  logic [IDX_W-1:0]         hit_idx;

  tlbreg_access u_access (
    .clk        (clk),
    .rst        (rst),
    .acc_en     (acc_en),
    .acc_wr     (acc_wr),
    .acc_ext    (acc_ext),
    .acc_reg    (acc_reg),
    .mmu_level  (mmu_level),
    .tlb_access (tlb_access),
    .strobe     (st),
    .rd_ok      (rd_ok)
  );

  tlbreg_store #(.ENTRIES(ENTRIES)) u_store (
    .clk      (clk),
    .rst      (rst),
    .sel      (index_q[IDX_W-1:0]),
    .wr_dlo   (st.wr_dlo),
    .wr_dhi   (st.wr_dhi),
    .wr_tag   (st.wr_tag),
    .wdata    (acc_wdata),
    .pid8     (pid_q[7:0]),
    .rd_dlo   (rd_dlo),
    .rd_dhi   (rd_dhi),
    .rd_tag   (rd_tag),
    .rd_tid   (rd_tid),
    .tag_all  (tag_all),
    .zone_all (zone_all),
    .tid_all  (tid_all)
  );

  tlbreg_search #(.ENTRIES(ENTRIES), .ZONE_MAX(ZONE_MAX)) u_search (
    .tag_all  (tag_all),
    .zone_all (zone_all),
    .tid_all  (tid_all),
    .vaddr    (page_bits(acc_wdata)),
    .pid8     (pid_q[7:0]),
    .zpr      (zpr_q),
    .user     (user_mode),
    .hit      (hit),
    .hit_idx  (hit_idx)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      index_q <= '0;
      pid_q   <= '0;
      zpr_q   <= '0;
    end else begin
      if (st.wr_index) index_q[30:0] <= acc_wdata[30:0];
      if (st.wr_search) begin
        if (hit) index_q <= 32'(hit_idx);
        else     index_q[31] <= 1'b1;
      end
      if (st.wr_pid)      pid_q <= acc_wdata;
      else if (st.rd_tag) pid_q <= {24'd0, rd_tid};
      if (st.wr_zone) zpr_q <= acc_wdata;
    end
  end

  always_comb begin
    acc_rdata = '0;
    if (rd_ok) begin
      case (acc_reg)
        RN_DATA:  acc_rdata = acc_ext ? rd_dhi : rd_dlo;
        RN_TAG:   acc_rdata = rd_tag;
        RN_INDEX: acc_rdata = index_q;
        RN_PID:   acc_rdata = pid_q;
        RN_ZONE:  acc_rdata = zpr_q;
        default:  acc_rdata = '0;
      endcase
    end
  end

  logic blocked;
  assign blocked = (mmu_level < 2'd2) || (tlb_access == 2'd0);

  // R2: disabled configurations freeze state and read zero
  p_blocked_write_r2: assert property (@(posedge clk) disable iff (rst)
    (acc_en && acc_wr && blocked) |=>
      $stable(index_q) && $stable(pid_q) && $stable(zpr_q));
  p_blocked_read_r2: assert property (@(posedge clk) disable iff (rst)
    blocked |-> (acc_rdata == 32'd0));

  // R7: tag write records the process ID in the entry
  p_tid_latch_r7: assert property (@(posedge clk) disable iff (rst)
    st.wr_tag |=> (rd_tid == $past(pid_q[7:0])));

  // R8: tag read loads the process ID from the entry
  p_pid_load_r8: assert property (@(posedge clk) disable iff (rst)
    st.rd_tag |=> (pid_q == {24'd0, $past(rd_tid)}));

  // R9: the miss flag survives index writes
  p_miss_flag_ro_r9: assert property (@(posedge clk) disable iff (rst)
    st.wr_index |=> (index_q[31] == $past(index_q[31])));

  // R12: search results
  p_hit_index_r12: assert property (@(posedge clk) disable iff (rst)
    (st.wr_search && hit) |=> (index_q == 32'($past(hit_idx))));
  p_miss_keep_r12: assert property (@(posedge clk) disable iff (rst)
    (st.wr_search && !hit) |=>
      index_q[31] && (index_q[30:0] == $past(index_q[30:0])));

endmodule

// File: tb/test_tlbreg_ctrl.sv
`timescale 1ns/1ps
module test_tlbreg_ctrl;

  localparam int E  = 8;
  localparam int ZM = 3;
  localparam int IW = $clog2(E);

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [1:0]  mmu_level = 2'd3;
  logic [1:0]  tlb_access = 2'd3;
  logic        user_mode = 1'b0;
  logic        acc_en = 1'b0;
  logic        acc_wr = 1'b0;
  logic        acc_ext = 1'b0;
  logic [2:0]  acc_reg = 3'd0;
  logic [31:0] acc_wdata = 32'd0;
  logic [31:0] acc_rdata;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  tlbreg_ctrl #(.ENTRIES(E), .ZONE_MAX(ZM)) i_tlbreg_ctrl (
    .clk(clk), .rst(rst), .mmu_level(mmu_level), .tlb_access(tlb_access),
    .user_mode(user_mode), .acc_en(acc_en), .acc_wr(acc_wr), .acc_ext(acc_ext),
    .acc_reg(acc_reg), .acc_wdata(acc_wdata), .acc_rdata(acc_rdata)
  );

  // reference state
  logic [31:0] m_tag [E];
  logic [63:0] m_dat [E];
  logic [7:0]  m_tid [E];
  logic [31:0] m_idx, m_pid, m_zpr;

  function automatic bit m_off();
    return (mmu_level < 2) || (tlb_access == 0);
  endfunction

  function automatic logic [31:0] m_read(input logic [2:0] rn, input bit ext);
    int e;
    e = int'(m_idx[IW-1:0]);
    if (m_off() || (ext && rn != 3'd0)) return 32'd0;
    case (rn)
      3'd0: return tlb_access[0] ? (ext ? m_dat[e][63:32] : m_dat[e][31:0]) : 32'd0;
      3'd1: return tlb_access[0] ? m_tag[e] : 32'd0;
      3'd2: return m_idx;
      3'd4: return tlb_access[0] ? m_pid : 32'd0;
      3'd5: return tlb_access[0] ? m_zpr : 32'd0;
      default: return 32'd0;
    endcase
  endfunction

  function automatic int m_search(input logic [31:0] va);
    for (int i = 0; i < E; i++) begin
      logic [31:0] t, msk;
      int z;
      logic [1:0] zf;
      t = m_tag[i];
      if (!t[6]) continue;
      msk = 32'hFFFF_FFFF << (10 + 2 * int'(t[9:7]));
      if ((va & msk) != (t & msk)) continue;
      if (m_tid[i] != 8'd0 && m_tid[i] != m_pid[7:0]) continue;
      z = int'(m_dat[i][7:4]);
      if (z > ZM) zf = 2'd1;
      else zf = 2'((m_zpr >> (30 - 2 * z)) & 32'd3);
      if (user_mode && zf == 2'd0) continue;
      return i;
    end
    return -1;
  endfunction

  task automatic m_update(input bit wr, input logic [2:0] rn, input bit ext,
                          input logic [31:0] v);
    int e, h;
    e = int'(m_idx[IW-1:0]);
    if (m_off() || (ext && rn != 3'd0)) return;
    if (!wr) begin
      if (rn == 3'd1 && tlb_access[0]) m_pid = {24'd0, m_tid[e]};
      return;
    end
    case (rn)
      3'd0: if (ext) m_dat[e][63:32] = v; else m_dat[e][31:0] = v;
      3'd1: begin m_tag[e] = v; m_tid[e] = m_pid[7:0]; end
      3'd2: m_idx[30:0] = v[30:0];
      3'd3: if (tlb_access > 1) begin
              h = m_search(v & 32'hFFFF_FC00);
              if (h >= 0) m_idx = 32'(h);
              else m_idx[31] = 1'b1;
            end
      3'd4: if (tlb_access > 1) m_pid = v;
      3'd5: if (tlb_access > 1) m_zpr = v;
      default: ;
    endcase
  endtask

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic acc(input bit wr, input logic [2:0] rn, input bit ext,
                     input logic [31:0] v, input string tag);
    @(negedge clk);
    acc_en = 1'b1; acc_wr = wr; acc_ext = ext; acc_reg = rn; acc_wdata = v;
    #1;
    if (!wr) check(tag, acc_rdata, m_read(rn, ext));
    @(posedge clk);
    #1;
    m_update(wr, rn, ext, v);
  endtask

  task automatic put_entry(input int i, input logic [31:0] tag, input logic [7:0] tid,
                           input logic [31:0] lo, input logic [31:0] hi);
    acc(1, 3'd4, 0, {24'd0, tid}, "R5");
    acc(1, 3'd2, 0, 32'(i), "R6");
    acc(1, 3'd1, 0, tag, "R7");
    acc(1, 3'd0, 0, lo, "R6");
    acc(1, 3'd0, 1, hi, "R3");
    acc(1, 3'd4, 0, 32'h0000_00AA, "R5");
    acc(0, 3'd1, 0, 0, "R6");
    acc(0, 3'd4, 0, 0, "R8");
    acc(0, 3'd0, 0, 0, "R6");
    acc(0, 3'd0, 1, 0, "R3");
  endtask

  function automatic logic [31:0] va_of(input int k);
    case (k)
      0: return 32'h0001_0000;   1: return 32'h0001_03FF;
      2: return 32'h0001_0400;   3: return 32'h01AB_CDEF;
      4: return 32'h00FF_FFFF;   5: return 32'h0200_3FFF;
      6: return 32'h0200_4123;   7: return 32'h0003_0C00;
      8: return 32'h0003_1000;   9: return 32'h0004_0000;
      10: return 32'h0005_FFFF;  11: return 32'h0006_0000;
      12: return 32'h0200_0000;  13: return 32'h0100_0000;
      14: return 32'hFFFF_FFFF;  default: return 32'h0000_0000;
    endcase
  endfunction

  function automatic string tag_of(input logic [2:0] rn, input bit ext);
    if (m_off()) return "R2";
    if (ext && rn != 3'd0) return "R3";
    if (rn == 3'd3 || rn > 3'd5) return "R13";
    if (rn != 3'd2 && !tlb_access[0]) return "R4";
    if (rn == 3'd0 && ext) return "R3";
    if (rn == 3'd2) return "R9";
    return "R6";
  endfunction

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    for (int i = 0; i < E; i++) begin m_tag[i] = 0; m_dat[i] = 0; m_tid[i] = 0; end
    m_idx = 0; m_pid = 0; m_zpr = 0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 1'b0;

    // R1: reset state
    acc(0, 3'd2, 0, 0, "R1");
    acc(0, 3'd4, 0, 0, "R1");
    acc(0, 3'd5, 0, 0, "R1");
    acc(0, 3'd0, 0, 0, "R1");
    acc(0, 3'd0, 1, 0, "R1");
    acc(0, 3'd1, 0, 0, "R1");
    acc(0, 3'd3, 0, 0, "R13");

    // table for searches: tag = base | size<<7 | valid
    put_entry(0, 32'h0001_0040,        8'd0, 32'h1000_0005, 32'hA000_0000);
    put_entry(1, 32'h0001_0040,        8'd0, 32'h2000_0015, 32'hA000_0001);
    put_entry(2, 32'h0100_03C0,        8'd5, 32'h3000_0025, 32'hA000_0002);
    put_entry(3, 32'h0200_0140,        8'd0, 32'h4000_0065, 32'hA000_0003);
    put_entry(4, 32'h0003_00C0,        8'd7, 32'h5000_0005, 32'hA000_0004);
    put_entry(5, 32'h0004_0000,        8'd0, 32'h6000_0005, 32'hA000_0005);
    put_entry(6, 32'h0005_01C0,        8'd0, 32'h7000_0035, 32'hA000_0006);
    put_entry(7, 32'h0200_4040,        8'd0, 32'h8000_0005, 32'hA000_0007);

    // R10 / R11 / R12: search sweep
    for (int zs = 0; zs < 3; zs++) begin
      for (int ps = 0; ps < 3; ps++) begin
        for (int us = 0; us < 2; us++) begin
          acc(1, 3'd5, 0, (zs == 0) ? 32'h0 : (zs == 1) ? 32'h5555_5555 : 32'h0FFF_FFFF, "R5");
          acc(1, 3'd4, 0, (ps == 0) ? 32'd0 : (ps == 1) ? 32'd5 : 32'd7, "R5");
          user_mode = us[0];
          for (int k = 0; k < 16; k++) begin
            acc(1, 3'd2, 0, 32'h0000_0002, "R9");
            acc(1, 3'd3, 0, va_of(k), "R12");
            acc(0, 3'd2, 0, 0, us ? "R11" : "R10");
          end
        end
      end
    end
    user_mode = 1'b0;

    // R9 / R12 directed: miss keeps low bits, flag read-only, hit clears it
    acc(1, 3'd2, 0, 32'h7FFF_FFF3, "R9");
    acc(1, 3'd3, 0, 32'hFFFF_FFFF, "R12");
    acc(0, 3'd2, 0, 0, "R12");
    acc(1, 3'd2, 0, 32'h0000_0000, "R9");
    acc(0, 3'd2, 0, 0, "R9");
    acc(1, 3'd3, 0, 32'h0200_4000, "R12");
    acc(0, 3'd2, 0, 0, "R12");

    // R2 / R3 / R4 / R13: read sweep over all configurations
    for (int lv = 0; lv < 4; lv++)
      for (int ac = 0; ac < 4; ac++)
        for (int rn = 0; rn < 8; rn++)
          for (int ex = 0; ex < 2; ex++) begin
            mmu_level = 2'(lv); tlb_access = 2'(ac);
            acc(0, 3'(rn), ex[0], 0, tag_of(3'(rn), ex[0]));
          end

    // R2 / R5 / R13: write sweep, then full readback
    for (int lv = 0; lv < 4; lv++)
      for (int ac = 0; ac < 4; ac++)
        for (int rn = 0; rn < 8; rn++)
          for (int ex = 0; ex < 2; ex++) begin
            mmu_level = 2'(lv); tlb_access = 2'(ac);
            acc(1, 3'(rn), ex[0], 32'((lv * 64 + ac * 16 + rn * 2 + ex + 1) * 32'h9E37_79B1), "R5");
          end
    mmu_level = 2'd3; tlb_access = 2'd3;
    acc(0, 3'd2, 0, 0, "R5");
    acc(0, 3'd4, 0, 0, "R5");
    acc(0, 3'd5, 0, 0, "R5");
    for (int e = 0; e < E; e++) begin
      acc(1, 3'd2, 0, 32'(e + 8 * e), "R6");
      acc(0, 3'd0, 0, 0, "R5");
      acc(0, 3'd0, 1, 0, "R3");
      acc(0, 3'd1, 0, 0, "R6");
      acc(0, 3'd4, 0, 0, "R7");
    end

    @(negedge clk) acc_en = 1'b0;
    finish_run();
  end

endmodule